// File: doc/BRIEF.md
# Trigger Handshake Sequencer

This block is a small bus master that launches a remote sequence engine once for every bit set in an 8-bit request map. It talks to the engine through three byte registers at fixed offsets from a base address: a trigger control register, a request register and a status register. For each requested bit it announces the bit, fires the trigger, polls the status register until that bit is acknowledged, then withdraws the announcement. It reports completion with a one-cycle `done` pulse and held `err` and `timeout` flags.

The register bus is a simple request/acknowledge bus. The master holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until the slave answers with a single-cycle `bus_ack`, which carries read data on `bus_rdata` and a failure indication on `bus_err`. A new request may follow the acknowledge without an idle cycle. Every change to a control bit is a read followed by a write of `(old & ~mask) | (value & mask)`, so bits the block does not own keep their values.

The state machine has the states IDLE, PRE_RD (read status before work), PRE_WR (clear a stale error code), PICK (choose the next requested bit), RMW_RD and RMW_WR (the two halves of a masked update, whose purpose is held in a step register: clear status bit, set request bit, fire trigger, drop request bit, drop status bit, final cleanup), POLL_RD (read status after triggering), WAIT (pause between polls), NACK_WR (clear the error code after a refusal) and DONE. Transitions: IDLE to DONE on a start with an empty map, IDLE to PRE_RD on any other start; PRE_RD to PRE_WR on 0xFF, else to PICK; PRE_WR to PICK; PICK to RMW_RD (clear step) when a bit remains, else to RMW_RD (cleanup step); RMW_WR chains the steps clear, set, fire, then POLL_RD; POLL_RD to NACK_WR on 0xFF, to RMW_RD (drop step) on acknowledge, to the cleanup step when the poll limit is spent, else to WAIT; WAIT to POLL_RD when the pause has elapsed; NACK_WR to the cleanup step; the drop steps return to PICK; the cleanup step ends in DONE, and DONE returns to IDLE. A bus error on any access goes to the cleanup step, or to DONE if it hits the cleanup itself.

Top module: `tseq_trigger_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `timeout` and `bus_req` are all low.
- R2: A start while idle with an all-zero map gives `done` and `err` high in the following cycle with no bus request.
- R3: The first access of a run reads the status register (base+0x51); if it returns 0xFF the next access writes 0x00 to it.
- R4: Requested bits are handled one at a time from bit 0 upward; clear map bits cause no accesses.
- R5: For each bit the order is: clear the bit in status (base+0x51), set it in request (base+0x50), set bit 7 of trigger control (base+0x42), then poll status.
- R6: Every control-bit change is a read of the register followed by a write that changes only the masked bits.
- R7: A poll reading 0xFF is a refusal: the block writes 0x00 to status, sets `err` and goes to cleanup; a poll with the current bit set is an acknowledge.
- R8: At most POLL_LIMIT polls are made per bit; each poll request starts POLL_GAP cycles after the previous poll completes; exhausting the limit sets `timeout` and `err` and goes to cleanup.
- R9: After an acknowledge the bit is cleared in request, then in status, before the next bit starts.
- R10: Every run with a non-empty map ends with one masked update of the request register clearing all requested bits, on success and on every failure.
- R11: A bus error response on any access sets `err` and sends the run to the cleanup step; an error during cleanup ends the run.
- R12: `busy` is high from start until the `done` pulse; a start while busy is ignored; `err` and `timeout` hold until the next accepted start.
- R13: While `bus_req` is high and no acknowledge has arrived, address, direction and write data do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| bitmap | input | 8 | Bits whose sequences are to be launched |
| base | input | ADDR_W | Base address of the register window |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run failed (empty map, refusal, timeout or bus error) |
| timeout | output | 1 | Poll limit exhausted |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Single-cycle access completion |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_err | input | 1 | Access failed, valid with bus_ack |

## Verification
The embedded properties watch every cycle for the bus holding its request steady, the trigger write always carrying bit 7, an empty map being refused in the next cycle without traffic, `busy` only falling after `done`, and the poll counter never going past its limit. The exact order of accesses, the masked write values, the stale-error pre-clear, the cleanup contents and the pause between polls depend on register contents and remote responses, so only the bench scenarios show them: a scoreboard predicts each access and the final register state from a model of the remote side, covering acknowledge, refusal, silence and injected bus errors.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
package tseq_pkg;

    localparam int          MAP_W     = 8;
    localparam logic [7:0]  OFS_TRIG  = 8'h42;
    localparam logic [7:0]  OFS_REQ   = 8'h50;
    localparam logic [7:0]  OFS_STAT  = 8'h51;
    localparam int          FIRE_BIT  = 7;
    localparam logic [7:0]  REFUSE    = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE_RD, ST_PRE_WR, ST_PICK, ST_RMW_RD, ST_RMW_WR,
        ST_POLL_RD, ST_WAIT, ST_NACK_WR, ST_DONE
    } st_e;

    typedef enum logic [2:0] {
        STP_CLR_STAT, STP_SET_REQ, STP_FIRE, STP_UNREQ, STP_UNSTAT, STP_CLEAN
    } step_e;

    typedef struct packed {
        logic [7:0] ofs;
        logic [7:0] mask;
        logic [7:0] val;
    } rmw_op_t;

    function automatic rmw_op_t step_op(step_e s, logic [7:0] one_bit, logic [7:0] whole_map);
        rmw_op_t o;
        unique case (s)
            STP_CLR_STAT: o = '{OFS_STAT, one_bit, 8'h00};
            STP_SET_REQ:  o = '{OFS_REQ,  one_bit, one_bit};
            STP_FIRE:     o = '{OFS_TRIG, 8'h80,   8'h80};
            STP_UNREQ:    o = '{OFS_REQ,  one_bit, 8'h00};
            STP_UNSTAT:   o = '{OFS_STAT, one_bit, 8'h00};
            default:      o = '{OFS_REQ,  whole_map, 8'h00};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/tseq_bit_pick.sv
`timescale 1ns/1ps
module tseq_bit_pick #(
    parameter int W = 8,
    localparam int IW = $clog2(W + 1),
    localparam int XW = $clog2(W)
) (
    input  logic [W-1:0]  map,
    input  logic [IW-1:0] from,
    output logic          found,
    output logic [XW-1:0] idx
);
    logic [W-1:0] elig;

    generate
        for (genvar i = 0; i < W; i++) begin : g_elig
            assign elig[i] = map[i] && (IW'(i) >= from);
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = XW'(i);
            end
        end
    end
endmodule

// File: rtl/tseq_poll_pacer.sv
`timescale 1ns/1ps
module tseq_poll_pacer #(
    parameter int LIMIT = 2000,
    parameter int GAP   = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic poll_taken,
    input  logic gap_load,
    input  logic gap_tick,
    output logic last_poll,
    output logic gap_zero
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam int GW = $clog2(GAP + 1);

    logic [CW-1:0] poll_cnt;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            if (arm)
                poll_cnt <= '0;
            else if (poll_taken)
                poll_cnt <= poll_cnt + 1'b1;
            if (gap_load)
                gap_cnt <= GW'(GAP - 1);
            else if (gap_tick && gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign last_poll = (poll_cnt == CW'(LIMIT - 1));
    assign gap_zero  = (gap_cnt == '0);

    // R8
    polls_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_taken |-> poll_cnt < CW'(LIMIT));
endmodule

// File: rtl/tseq_trigger_seq.sv
`timescale 1ns/1ps
module tseq_trigger_seq
    import tseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int POLL_LIMIT = 2000,
    parameter int POLL_GAP   = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        bitmap,
    input  logic [ADDR_W-1:0] base,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              timeout,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_err
);
    localparam int IW = $clog2(MAP_W + 1);
    localparam int XW = $clog2(MAP_W);

    st_e               state_q, state_d;
    step_e             step_q, step_d;
    logic [7:0]        map_q;
    logic [ADDR_W-1:0] base_q;
    logic [XW-1:0]     cur_q;
    logic [IW-1:0]     scan_q;
    logic [7:0]        old_q;
    logic              err_q, to_q;
    logic              fail_set, to_set;
    logic              found;
    logic [XW-1:0]     pick_idx;
    logic              last_poll, gap_zero;
    logic [7:0]        cur_bit;
    rmw_op_t           op;

    assign cur_bit = 8'b1 << cur_q;
    assign op      = step_op(step_q, cur_bit, map_q);

    tseq_bit_pick #(.W(MAP_W)) u_pick (
        .map   (map_q),
        .from  (scan_q),
        .found (found),
        .idx   (pick_idx)
    );

    tseq_poll_pacer #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (state_q == ST_RMW_WR && bus_ack && step_q == STP_FIRE),
        .poll_taken (state_q == ST_POLL_RD && bus_ack),
        .gap_load   (state_q == ST_POLL_RD && bus_ack),
        .gap_tick   (state_q == ST_WAIT),
        .last_poll  (last_poll),
        .gap_zero   (gap_zero)
    );

    // next state and step
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        fail_set = 1'b0;
        to_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = (bitmap == '0) ? ST_DONE : ST_PRE_RD;
            end
            ST_PRE_RD: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        fail_set = 1'b1;
                        state_d  = ST_RMW_RD;
                        step_d   = STP_CLEAN;
                    end else if (bus_rdata == REFUSE) begin
                        state_d = ST_PRE_WR;
                    end else begin
                        state_d = ST_PICK;
                    end
                end
            end
            ST_PRE_WR: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        fail_set = 1'b1;
                        state_d  = ST_RMW_RD;
                        step_d   = STP_CLEAN;
                    end else begin
                        state_d = ST_PICK;
                    end
                end
            end
            ST_PICK: begin
                state_d = ST_RMW_RD;
                step_d  = found ? STP_CLR_STAT : STP_CLEAN;
            end
            ST_RMW_RD, ST_RMW_WR: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        fail_set = 1'b1;
                        state_d  = (step_q == STP_CLEAN) ? ST_DONE : ST_RMW_RD;
                        step_d   = STP_CLEAN;
                    end else if (state_q == ST_RMW_RD) begin
                        state_d = ST_RMW_WR;
                    end else begin
                        unique case (step_q)
                            STP_CLR_STAT: begin state_d = ST_RMW_RD; step_d = STP_SET_REQ; end
                            STP_SET_REQ:  begin state_d = ST_RMW_RD; step_d = STP_FIRE;    end
                            STP_FIRE:     state_d = ST_POLL_RD;
                            STP_UNREQ:    begin state_d = ST_RMW_RD; step_d = STP_UNSTAT;  end
                            STP_UNSTAT:   state_d = ST_PICK;
                            default:      state_d = ST_DONE;
                        endcase
                    end
                end
            end
            ST_POLL_RD: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        fail_set = 1'b1;
                        state_d  = ST_RMW_RD;
                        step_d   = STP_CLEAN;
                    end else if (bus_rdata == REFUSE) begin
                        fail_set = 1'b1;
                        state_d  = ST_NACK_WR;
                    end else if ((bus_rdata & cur_bit) != '0) begin
                        state_d = ST_RMW_RD;
                        step_d  = STP_UNREQ;
                    end else if (last_poll) begin
                        fail_set = 1'b1;
                        to_set   = 1'b1;
                        state_d  = ST_RMW_RD;
                        step_d   = STP_CLEAN;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (gap_zero)
                    state_d = ST_POLL_RD;
            end
            ST_NACK_WR: begin
                if (bus_ack) begin
                    if (bus_err)
                        fail_set = 1'b1;
                    state_d = ST_RMW_RD;
                    step_d  = STP_CLEAN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STP_CLEAN;
            map_q   <= '0;
            base_q  <= '0;
            cur_q   <= '0;
            scan_q  <= '0;
            old_q   <= '0;
            err_q   <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (state_q == ST_IDLE && start) begin
                map_q  <= bitmap;
                base_q <= base;
                scan_q <= '0;
                err_q  <= (bitmap == '0);
                to_q   <= 1'b0;
            end else begin
                if (fail_set) err_q <= 1'b1;
                if (to_set)   to_q  <= 1'b1;
            end
            if (state_q == ST_PICK && found)
                cur_q <= pick_idx;
            if (state_q == ST_RMW_RD && bus_ack)
                old_q <= bus_rdata;
            if (state_q == ST_RMW_WR && bus_ack && !bus_err && step_q == STP_UNSTAT)
                scan_q <= IW'(cur_q) + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = base_q + ADDR_W'(OFS_STAT);
        bus_wdata = '0;
        unique case (state_q)
            ST_PRE_RD, ST_POLL_RD: begin
                bus_req = 1'b1;
            end
            ST_PRE_WR, ST_NACK_WR: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            ST_RMW_RD: begin
                bus_req  = 1'b1;
                bus_addr = base_q + ADDR_W'(op.ofs);
            end
            ST_RMW_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_q + ADDR_W'(op.ofs);
                bus_wdata = (old_q & ~op.mask) | (op.val & op.mask);
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign err     = err_q;
    assign timeout = to_q;

    // R2
    zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bitmap == '0) |=> (done && err && !bus_req));

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R5
    fire_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == base_q + ADDR_W'(OFS_TRIG)) |-> bus_wdata[FIRE_BIT]);

    // R8
    timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> err);

    // R12
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_tseq_trigger_seq.sv
`timescale 1ns/1ps
module sim_tseq_trigger_seq;
    import tseq_pkg::*;

    localparam int AW  = 16;
    localparam int LIM = 4;
    localparam int GAP = 5;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } xact_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          start = 1'b0;
    logic [7:0]    bitmap = '0;
    logic [AW-1:0] base = '0;
    logic          busy, done, err, timeout;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack, bus_err;
    logic [7:0]    bus_rdata;

    tseq_trigger_seq #(.ADDR_W(AW), .POLL_LIMIT(LIM), .POLL_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bitmap(bitmap), .base(base),
        .busy(busy), .done(done), .err(err), .timeout(timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_tag = "R1";
    xact_t exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // ---------------- remote side model ----------------
    logic [AW-1:0] cur_base = 16'h1000;
    int   eng_mode = 0;       // 0 acknowledge, 1 refuse, 2 silent
    int   eng_polls = 0;
    int   err_at = -1;
    logic ld_en = 1'b0;
    logic [7:0] ld_trig = '0, ld_req = '0, ld_stat = '0;

    logic [7:0] s_trig, s_req, s_stat;
    logic       s_pend, ack_r;
    int         s_left, acc_idx;
    logic [7:0] ofs_now, resp_val;
    logic       respond_now;

    always_comb begin
        ofs_now     = 8'(bus_addr - cur_base);
        resp_val    = (eng_mode == 1) ? 8'hFF : (s_stat | s_req);
        respond_now = (ofs_now == OFS_STAT) && s_pend && eng_mode != 2 && s_left == 0;
        if (respond_now)                bus_rdata = resp_val;
        else if (ofs_now == OFS_STAT)   bus_rdata = s_stat;
        else if (ofs_now == OFS_REQ)    bus_rdata = s_req;
        else if (ofs_now == OFS_TRIG)   bus_rdata = s_trig;
        else                            bus_rdata = 8'h00;
    end
    assign bus_ack = ack_r;
    assign bus_err = ack_r && (acc_idx == err_at);

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0; s_trig <= '0; s_req <= '0; s_stat <= '0;
            s_pend <= 1'b0; s_left <= 0; acc_idx <= 0;
        end else if (ld_en) begin
            ack_r <= 1'b0; s_trig <= ld_trig; s_req <= ld_req; s_stat <= ld_stat;
            s_pend <= 1'b0; s_left <= 0; acc_idx <= 0;
        end else begin
            ack_r <= bus_req && !ack_r;
            if (bus_req && ack_r) begin
                acc_idx <= acc_idx + 1;
                if (!bus_err) begin
                    if (bus_we) begin
                        if (ofs_now == OFS_STAT) s_stat <= bus_wdata;
                        if (ofs_now == OFS_REQ)  s_req  <= bus_wdata;
                        if (ofs_now == OFS_TRIG) begin
                            s_trig <= bus_wdata;
                            if (bus_wdata[7]) begin s_pend <= 1'b1; s_left <= eng_polls; end
                        end
                    end else if (ofs_now == OFS_STAT && s_pend && eng_mode != 2) begin
                        if (s_left == 0) begin s_stat <= resp_val; s_pend <= 1'b0; end
                        else s_left <= s_left - 1;
                    end
                end
            end
        end
    end

    // ---------------- expectation generator ----------------
    logic [7:0] m_trig, m_req, m_stat;
    int g_n, g_errat;

    function automatic logic [7:0] mget(input logic [7:0] ofs);
        if (ofs == OFS_STAT) return m_stat;
        if (ofs == OFS_REQ)  return m_req;
        return m_trig;
    endfunction

    task automatic ex(input bit we, input logic [7:0] ofs, input logic [7:0] d, output bit e);
        xact_t x;
        x.we = we; x.addr = cur_base + AW'(ofs); x.data = d;
        exp_q.push_back(x);
        e = (g_n == g_errat);
        g_n++;
        if (we && !e) begin
            if (ofs == OFS_STAT) m_stat = d;
            else if (ofs == OFS_REQ) m_req = d;
            else m_trig = d;
        end
    endtask

    task automatic ex_rmw(input logic [7:0] ofs, input logic [7:0] mask, input logic [7:0] val, output bit e);
        logic [7:0] old;
        old = mget(ofs);
        ex(1'b0, ofs, 8'h00, e);
        if (e) return;
        ex(1'b1, ofs, (old & ~mask) | (val & mask), e);
    endtask

    task automatic plan(input logic [7:0] bm, input int mode, input int polls, output bit xe, output bit xt);
        bit e, ab, resp;
        xe = 1'b0; xt = 1'b0; g_n = 0; ab = 1'b0;
        if (bm == 8'h00) begin xe = 1'b1; return; end
        ex(1'b0, OFS_STAT, 8'h00, e); ab = e;
        if (!ab && m_stat == 8'hFF) begin ex(1'b1, OFS_STAT, 8'h00, e); ab = e; end
        for (int b = 0; b < 8; b++) begin
            logic [7:0] bm1;
            bm1 = 8'b1 << b;
            if (!ab && bm[b]) begin
                ex_rmw(OFS_STAT, bm1, 8'h00, e); ab = e;
                if (!ab) begin ex_rmw(OFS_REQ, bm1, bm1, e); ab = e; end
                if (!ab) begin ex_rmw(OFS_TRIG, 8'h80, 8'h80, e); ab = e; end
                resp = 1'b0;
                for (int p = 0; p < LIM && !ab && !resp; p++) begin
                    ex(1'b0, OFS_STAT, 8'h00, e);
                    if (e) ab = 1'b1;
                    else begin
                        if (p == polls && mode != 2)
                            m_stat = (mode == 1) ? 8'hFF : (m_stat | m_req);
                        if (m_stat == 8'hFF) begin ex(1'b1, OFS_STAT, 8'h00, e); ab = 1'b1; end
                        else if (m_stat[b]) resp = 1'b1;
                        else if (p == LIM - 1) begin ab = 1'b1; xt = 1'b1; end
                    end
                end
                if (resp) begin
                    ex_rmw(OFS_REQ, bm1, 8'h00, e); ab = e;
                    if (!ab) begin ex_rmw(OFS_STAT, bm1, 8'h00, e); ab = e; end
                end
            end
        end
        ex_rmw(OFS_REQ, bm, 8'h00, e);
        if (e) ab = 1'b1;
        xe = ab;
    endtask

    // ---------------- monitor ----------------
    logic          held_v = 1'b0;
    logic [AW-1:0] held_addr;
    bit            in_poll = 1'b0, prev_poll = 1'b0;
    int            prev_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && bus_req && !bus_ack && !held_v) begin
            held_v = 1'b1; held_addr = bus_addr;
        end
        if (rst_n && bus_req && bus_ack) begin
            xact_t x;
            if (held_v) check(bus_addr == held_addr, "R13", "address moved before ack", bus_addr, held_addr);
            held_v = 1'b0;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected access", bus_addr, 0);
            end else begin
                x = exp_q.pop_front();
                check(bus_we == x.we && bus_addr == x.addr, cur_tag, "access kind/address",
                      {bus_we, bus_addr}, {x.we, x.addr});
                if (x.we) check(bus_wdata == x.data, cur_tag, "write data", bus_wdata, x.data);
            end
            if (bus_we) begin
                prev_poll = 1'b0;
                in_poll = (bus_addr == cur_base + AW'(OFS_TRIG));
            end else if (in_poll && bus_addr == cur_base + AW'(OFS_STAT)) begin
                if (prev_poll) check(cyc - prev_cyc == GAP + 2, "R8", "poll spacing", cyc - prev_cyc, GAP + 2);
                prev_poll = 1'b1;
                prev_cyc = cyc;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run(input string tag, input logic [7:0] bm, input logic [7:0] st0,
                       input logic [7:0] rq0, input logic [7:0] tg0, input int mode,
                       input int polls, input int errat, input logic [AW-1:0] b, input bit dbl);
        bit xe, xt;
        int k;
        @(negedge clk);
        cur_tag = tag; cur_base = b; eng_mode = mode; eng_polls = polls; err_at = errat;
        ld_trig = tg0; ld_req = rq0; ld_stat = st0; ld_en = 1'b1;
        in_poll = 1'b0; prev_poll = 1'b0;
        @(negedge clk);
        ld_en = 1'b0;
        m_trig = tg0; m_req = rq0; m_stat = st0; g_errat = errat;
        plan(bm, mode, polls, xe, xt);
        bitmap = bm; base = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bm == 8'h00) begin
            check(done && err && !bus_req, "R2", "empty map refusal", {done, err, bus_req}, 3'b110);
        end else begin
            k = 0;
            while (!done && k < 3000) begin
                @(negedge clk);
                k++;
                if (dbl && k == 4) begin bitmap = 8'h00; start = 1'b1; end
                else start = 1'b0;
            end
            check(done, tag, "run finished", done, 1);
        end
        check(err == xe, tag, "err flag", err, xe);
        check(timeout == xt, tag, "timeout flag", timeout, xt);
        check(exp_q.size() == 0, tag, "accesses left unseen", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        check(!busy && !done && err == xe && timeout == xt, "R12", "flags held, idle after done",
              {busy, done, err, timeout}, {2'b00, xe, xt});
        check(s_req == m_req, "R10", "request register after run", s_req, m_req);
        check(s_stat == m_stat, "R9", "status register after run", s_stat, m_stat);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !timeout && !bus_req, "R1", "reset state",
              {busy, done, err, timeout, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run("R2",  8'h00, 8'h00, 8'h00, 8'h00, 0, 0, -1, 16'h1000, 1'b0);
        run("R9",  8'h01, 8'h00, 8'h00, 8'h00, 0, 0, -1, 16'h1000, 1'b0);
        run("R4",  8'hA5, 8'h00, 8'h00, 8'h11, 0, 2, -1, 16'h1000, 1'b0);
        run("R6",  8'h12, 8'h20, 8'h40, 8'h03, 0, 1, -1, 16'h2300, 1'b0);
        run("R3",  8'h02, 8'hFF, 8'h00, 8'h00, 0, 0, -1, 16'h1000, 1'b0);
        run("R7",  8'h0C, 8'h00, 8'h01, 8'h00, 1, 1, -1, 16'h1000, 1'b0);
        run("R8",  8'h80, 8'h00, 8'h00, 8'h00, 2, 0, -1, 16'h1000, 1'b0);
        run("R11", 8'h03, 8'h00, 8'h00, 8'h00, 0, 0,  5, 16'h1000, 1'b0);
        run("R10", 8'h10, 8'h00, 8'h90, 8'h00, 0, 0,  0, 16'h1000, 1'b0);
        run("R5",  8'h40, 8'h00, 8'h00, 8'h7F, 0, 3, -1, 16'h0400, 1'b0);
        run("R12", 8'h06, 8'h00, 8'h00, 8'h00, 0, 1, -1, 16'h1000, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule